// File: doc/BRIEF.md
# Ringing Access Switch State Controller

This block is the digital control core of a four-switch ringing access element on an analog telephone line card. A command input chooses between the talk path and the ringing path. In the talk path, two line-break switches connect the line to the subscriber interface circuit. In the ringing path, a ring-return switch and a ringing-access switch connect the line to the ringing generator. The command passes through a level-controlled capture stage, so a controller can set the state and then freeze it.

Three things can force every switch open. The first is an active-low override pin. The second is a battery-loss monitor with hysteresis. The third is a thermal monitor with hysteresis. The override is never captured. The two monitors release on their own, and the state captured before the fault then returns. The ringing-access switch behaves like a thyristor: once it is on, it turns off only on a current zero crossing, which arrives as a single-cycle strobe.

The control pins are plain levels, and the switch enables are plain outputs. No data stream passes through the block, so there is no valid/ready interface and no back-pressure.

Top module: `rac_switch_ctrl`

## Requirements
- R1: When the captured command is 0, no fault is set and force_off_n is 1, the next clock edge drives both line_brk_en bits to 1 and ring_ret_en to 0 (talk state).
- R2: When the captured command is 1, no fault is set and force_off_n is 1, the next clock edge drives line_brk_en to 0 and both ring_ret_en and ring_acc_en to 1 (ringing state).
- R3: At a clock edge where hold_in is 0, the captured command takes ctl_in. At an edge where hold_in is 1, the captured command keeps its previous value and ctl_in is ignored.
- R4: At an edge where force_off_n is 0, line_brk_en and ring_ret_en go to 0, whatever ctl_in and hold_in are. The override is not captured: at the first edge with force_off_n back at 1, the captured command takes effect again.
- R5: Once ring_acc_en is 1, it stays 1 until an edge where zc_strobe is 1 and ringing is not commanded. At that edge it clears. This also applies when the forced-off state is caused by the override or by a fault.
- R6: At an edge where the signed code bat_code (volts) is above -10, the battery fault sets and all switches are forced off. The fault clears only at an edge where bat_code is below -15. Between those levels the fault keeps its previous value.
- R7: At an edge where the unsigned code temp_code (degrees C) is 110 or more, the thermal fault sets. All switches are forced off and therm_ok goes to 0. The fault clears only at an edge where temp_code is below 95, and the captured state then returns.
- R8: During reset and after it, before any stimulus, the outputs are in the talk state: line_brk_en = 2'b11, ring_ret_en = 0, ring_acc_en = 0, therm_ok = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_in | input | 1 | Switch command: 1 selects ringing, 0 selects talk |
| hold_in | input | 1 | Capture control: 0 passes ctl_in through, 1 freezes the command |
| force_off_n | input | 1 | Active-low override that opens all switches |
| bat_code | input | 8 | Signed battery voltage code, in volts |
| temp_code | input | 8 | Unsigned die temperature code, in degrees C |
| zc_strobe | input | 1 | Single-cycle pulse marking a current zero crossing |
| line_brk_en | output | 2 | Line-break switch enables, one bit per pole |
| ring_ret_en | output | 1 | Ring-return switch enable |
| ring_acc_en | output | 1 | Ringing-access switch enable |
| therm_ok | output | 1 | High in normal operation, low during thermal shutdown |

## Verification
Directed sequences come first.
- A talk-to-ring-to-talk walk with the strobe held low, then pulsed, shows that the line-break switches close before the ringing-access switch releases.
- Toggling ctl_in while hold_in is high tells a frozen command apart from a transparent one.
- Battery and temperature codes are stepped into the band between the two thresholds, from both sides, so that hysteresis can be told apart from a single threshold.
- Pulling the override low while the command is frozen shows that the override bypasses the capture stage.

After that, seeded random traffic mixes all the inputs. It catches interactions between the fault paths and the ringing-access hold.

// File: rtl/rac_pkg.sv
package rac_pkg;
  localparam int unsigned NUM_POLES = 2;
  localparam int unsigned BAT_W     = 8;
  localparam int unsigned TEMP_W    = 8;

  typedef struct packed {
    logic [NUM_POLES-1:0] brk;
    logic                 ret;
  } rac_path_t;

  function automatic rac_path_t rac_decode(input logic cmd, input logic off);
    rac_path_t p;
    p.brk = (off || cmd) ? '0 : '1;
    p.ret = !off && cmd;
    return p;
  endfunction
endpackage

// File: rtl/rac_cmd_latch.sv
module rac_cmd_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl,
  input  logic hold,
  output logic cmd_eff,
  output logic cmd_q
);
  assign cmd_eff = hold ? cmd_q : ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= 1'b0;
    else        cmd_q <= cmd_eff;
  end
endmodule

// File: rtl/rac_hyst_mon.sv
module rac_hyst_mon #(
  parameter int unsigned W       = 8,
  parameter int          SET_LVL = 0,
  parameter int          CLR_LVL = -1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] val,
  output logic                flt_nxt,
  output logic                flt_q
);
  localparam logic signed [W-1:0] SET_C = SET_LVL[W-1:0];
  localparam logic signed [W-1:0] CLR_C = CLR_LVL[W-1:0];

  always_comb begin
    if (val >= SET_C)      flt_nxt = 1'b1;
    else if (val < CLR_C)  flt_nxt = 1'b0;
    else                   flt_nxt = flt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flt_q <= 1'b0;
    else        flt_q <= flt_nxt;
  end
endmodule

// File: rtl/rac_ring_hold.sv
module rac_ring_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic ring_cmd,
  input  logic zc,
  output logic ring_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ring_q <= 1'b0;
    else if (ring_cmd) ring_q <= 1'b1;
    else if (zc)       ring_q <= 1'b0;
  end
endmodule

// File: rtl/rac_switch_ctrl.sv
module rac_switch_ctrl #(
  parameter int unsigned BAT_W      = rac_pkg::BAT_W,
  parameter int unsigned TEMP_W     = rac_pkg::TEMP_W,
  parameter int          BAT_OFF_V  = -10,
  parameter int          BAT_ON_V   = -15,
  parameter int          TEMP_OFF_C = 110,
  parameter int          TEMP_HYST  = 15
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ctl_in,
  input  logic                          hold_in,
  input  logic                          force_off_n,
  input  logic signed [BAT_W-1:0]       bat_code,
  input  logic [TEMP_W-1:0]             temp_code,
  input  logic                          zc_strobe,
  output logic [rac_pkg::NUM_POLES-1:0] line_brk_en,
  output logic                          ring_ret_en,
  output logic                          ring_acc_en,
  output logic                          therm_ok
);
  import rac_pkg::*;

  localparam int BAT_SET_LVL  = BAT_OFF_V + 1;
  localparam int TEMP_CLR_LVL = TEMP_OFF_C - TEMP_HYST;
  localparam int unsigned TW  = TEMP_W + 1;

  logic cmd_eff, cmd_q;
  logic bat_nxt, bat_q, th_nxt, th_q;
  logic all_off;
  logic signed [TW-1:0] temp_s;
  rac_path_t path_nxt;

  rac_cmd_latch u_latch (
    .clk(clk), .rst_n(rst_n), .ctl(ctl_in), .hold(hold_in),
    .cmd_eff(cmd_eff), .cmd_q(cmd_q)
  );

  rac_hyst_mon #(.W(BAT_W), .SET_LVL(BAT_SET_LVL), .CLR_LVL(BAT_ON_V)) u_bat (
    .clk(clk), .rst_n(rst_n), .val(bat_code), .flt_nxt(bat_nxt), .flt_q(bat_q)
  );

  assign temp_s = $signed({1'b0, temp_code});

  rac_hyst_mon #(.W(TW), .SET_LVL(TEMP_OFF_C), .CLR_LVL(TEMP_CLR_LVL)) u_therm (
    .clk(clk), .rst_n(rst_n), .val(temp_s), .flt_nxt(th_nxt), .flt_q(th_q)
  );

  assign all_off  = !force_off_n || bat_nxt || th_nxt;
  assign path_nxt = rac_decode(cmd_eff, all_off);

  genvar gp;
  generate
    for (gp = 0; gp < NUM_POLES; gp++) begin : g_pole
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_brk_en[gp] <= 1'b1;
        else        line_brk_en[gp] <= path_nxt.brk[gp];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_ret_en <= 1'b0;
      therm_ok    <= 1'b1;
    end else begin
      ring_ret_en <= path_nxt.ret;
      therm_ok    <= !th_nxt;
    end
  end

  rac_ring_hold u_ring (
    .clk(clk), .rst_n(rst_n), .ring_cmd(path_nxt.ret), .zc(zc_strobe), .ring_q(ring_acc_en)
  );
endmodule

// File: rtl/rac_switch_ctrl_chk.sv
module rac_switch_ctrl_chk #(
  parameter int BAT_OFF_V = -10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold_in,
  input logic              force_off_n,
  input logic signed [7:0] bat_code,
  input logic              zc_strobe,
  input logic [1:0]        line_brk_en,
  input logic              ring_ret_en,
  input logic              ring_acc_en,
  input logic              therm_ok,
  input logic              cmd_eff,
  input logic              cmd_q,
  input logic              all_off
);
  AST_TALK_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_off && !cmd_eff) |=> (line_brk_en == 2'b11 && !ring_ret_en)); // R1
  AST_RING_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_off && cmd_eff) |=> (line_brk_en == 2'b00 && ring_ret_en && ring_acc_en)); // R2
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    hold_in |=> (cmd_q == $past(cmd_q))); // R3
  AST_OVERRIDE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !force_off_n |=> (line_brk_en == 2'b00 && !ring_ret_en)); // R4
  AST_RING_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_acc_en && !zc_strobe) |=> ring_acc_en); // R5
  AST_RING_ZC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ring_acc_en) |-> $past(zc_strobe)); // R5
  AST_BAT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_code > BAT_OFF_V) |=> (line_brk_en == 2'b00 && !ring_ret_en)); // R6
  AST_THERM_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !therm_ok |-> (line_brk_en == 2'b00 && !ring_ret_en)); // R7
endmodule

bind rac_switch_ctrl rac_switch_ctrl_chk #(.BAT_OFF_V(BAT_OFF_V)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_in(hold_in), .force_off_n(force_off_n),
  .bat_code(bat_code), .zc_strobe(zc_strobe), .line_brk_en(line_brk_en),
  .ring_ret_en(ring_ret_en), .ring_acc_en(ring_acc_en), .therm_ok(therm_ok),
  .cmd_eff(cmd_eff), .cmd_q(cmd_q), .all_off(all_off)
);

// File: tb/sim_rac_switch_ctrl.sv
`timescale 1ns/1ps
module sim_rac_switch_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl = 1'b0, hold = 1'b0, ovr_n = 1'b1, zc = 1'b0;
  logic signed [7:0] bat = -8'sd48;
  logic [7:0] temp = 8'd40;
  logic [1:0] brk;
  logic ret, ring, tok;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic m_cmd = 1'b0, m_batf = 1'b0, m_thf = 1'b0, m_ring = 1'b0;
  logic m_off, m_eff;
  logic [4:0] m_exp = 5'b11001;

  always #2.5 clk = ~clk;

  rac_switch_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ctl_in(ctl), .hold_in(hold), .force_off_n(ovr_n),
    .bat_code(bat), .temp_code(temp), .zc_strobe(zc),
    .line_brk_en(brk), .ring_ret_en(ret), .ring_acc_en(ring), .therm_ok(tok)
  );

  function automatic logic hyst(input logic f, input int v, input int set_lvl, input int clr_lvl);
    if (v >= set_lvl) return 1'b1;
    if (v < clr_lvl)  return 1'b0;
    return f;
  endfunction

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {brk,ret,ring,tok} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic h, input logic o, input int b, input int t, input logic z);
    @(negedge clk);
    ctl = c; hold = h; ovr_n = o; bat = 8'(b); temp = 8'(t); zc = z;
    m_eff  = h ? m_cmd : c;
    m_cmd  = m_eff;
    m_batf = hyst(m_batf, b, -9, -15);
    m_thf  = hyst(m_thf, t, 110, 95);
    m_off  = !o || m_batf || m_thf;
    if (!m_off && m_eff) m_ring = 1'b1;
    else if (z)          m_ring = 1'b0;
    m_exp = {{2{!m_off && !m_eff}}, !m_off && m_eff, m_ring, !m_thf};
    @(posedge clk);
    #1;
  endtask

  function automatic logic [4:0] outs();
    return {brk, ret, ring, tok};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R8 in reset", outs(), 5'b11001);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R8 after reset", outs(), 5'b11001);

    step(0, 0, 1, -48, 40, 0); chk("R1 talk", outs(), 5'b11001);
    step(1, 0, 1, -48, 40, 0); chk("R2 ringing", outs(), 5'b00111);
    step(0, 1, 1, -48, 40, 0); chk("R3 frozen ring", outs(), 5'b00111);
    step(0, 1, 1, -48, 40, 1); chk("R3 frozen, zc ignored while commanded", outs(), 5'b00111);
    step(0, 0, 1, -48, 40, 0); chk("R5 talk before release", outs(), 5'b11011);
    step(0, 0, 1, -48, 40, 0); chk("R5 still waiting", outs(), 5'b11011);
    step(0, 0, 1, -48, 40, 1); chk("R5 released on zc", outs(), 5'b11001);
    step(1, 0, 1, -48, 40, 0); chk("R2 ringing again", outs(), 5'b00111);
    step(0, 1, 0, -48, 40, 0); chk("R4 override while frozen", outs(), 5'b00011);
    step(0, 0, 0, -48, 40, 1); chk("R4 override, ring releases on zc", outs(), 5'b00001);
    step(1, 1, 1, -48, 40, 0); chk("R4 override removed, frozen talk returns", outs(), 5'b11001);
    step(1, 0, 1, -48, 40, 0); chk("R2 ring", outs(), 5'b00111);
    step(1, 0, 1, -9, 40, 0);  chk("R6 battery lost", outs(), 5'b00011);
    step(1, 0, 1, -12, 40, 0); chk("R6 in band stays off", outs(), 5'b00011);
    step(1, 0, 1, -15, 40, 0); chk("R6 at -15 stays off", outs(), 5'b00011);
    step(1, 0, 1, -16, 40, 0); chk("R6 restored", outs(), 5'b00111);
    step(1, 0, 1, -11, 40, 0); chk("R6 in band from below stays on", outs(), 5'b00111);
    step(1, 1, 1, -48, 109, 0); chk("R7 below trip", outs(), 5'b00111);
    step(0, 1, 1, -48, 110, 1); chk("R7 thermal trip", outs(), 5'b00000);
    step(0, 1, 1, -48, 95, 0);  chk("R7 at 95 stays off", outs(), 5'b00000);
    step(0, 1, 1, -48, 94, 0);  chk("R7 cooled, captured ring returns", outs(), 5'b00111);

    for (int i = 0; i < 3000; i++) begin
      logic c, h, o, z;
      int b, t;
      c = 1'($urandom % 2);
      h = ($urandom % 4) == 0;
      o = ($urandom % 10) != 0;
      z = ($urandom % 6) == 0;
      b = int'($urandom % 31) - 30;
      t = 80 + int'($urandom % 51);
      step(c, h, o, b, t, z);
      chk("R1-R7 mix (random)", outs(), m_exp);
    end

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule